// File: doc/BRIEF.md
# Guarded Interrupt Vector Base Selector

This block holds the small control register that decides where the interrupt vector table lives in program memory. The table starts either at word address zero or at the first word of a boot region whose size comes from a 2-bit configuration input. For any interrupt index presented on its input, the block computes the matching vector word address. Vector entries are consecutive words counted from the chosen base.

The placement bit cannot be flipped by a single stray store. Software must first set an unlock bit, which opens a short timed window. Within that window it must store the new placement while clearing the unlock bit. While the window is open, and after a committed change until the CPU reports the end of the next instruction, the block raises a separate interrupt-block output. The CPU's own global interrupt flag is never touched.

Two lock inputs add a further rule. Depending on where the table sits, they hold interrupts off while the program counter is in the opposite region of memory.

Top module: `ivec_reloc_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_block` is low when both lock inputs are low, and `vec_addr` equals `irq_index`.
- R2: Any write updates register bits 7 and 6 (two external-interrupt enables) directly. Bits 5 to 2 always read 0.
- R3: The boot region start is 0xC00, 0xE00, 0xF00 or 0xF80 words for `boot_size` values 0, 1, 2 and 3.
- R4: `vec_addr` is the base plus `irq_index`. The base is 0 when the placement bit (bit 1) is 0, and the boot region start when it is 1.
- R5: A write with bit 0 set arms the unlock bit. It then reads 1 for exactly four cycles after the write and clears itself in the fifth.
- R6: A write with bit 0 clear, made while the unlock bit reads 1, loads bit 1 from the written data and clears the unlock bit. A write to bit 1 at any other time leaves bit 1 unchanged.
- R7: `irq_block` is high in the cycle of the arming write and in every cycle the unlock bit reads 1. After a window expires unused, it falls in the cycle the unlock bit clears.
- R8: After a committed placement write, `irq_block` stays high until the first `instr_done` pulse in a later cycle, and falls in the cycle after that pulse.
- R9: With bit 1 at 1 and `lock_app` high, `irq_block` is high whenever `pc` is below the boot region start.
- R10: With bit 1 at 0 and `lock_boot` high, `irq_block` is high whenever `pc` is at or above the boot region start.
- R11: An arming write made while the window is already open restarts the four-cycle window and leaves bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| reg_q | output | 8 | Register read value |
| boot_size | input | 2 | Boot region size select |
| lock_app | input | 1 | Application-side lock programmed |
| lock_boot | input | 1 | Boot-side lock programmed |
| pc | input | PC_W (12) | Current program counter, in words |
| instr_done | input | 1 | Instruction-complete pulse |
| irq_index | input | IDX_W (5) | Interrupt number to translate |
| vec_addr | output | PC_W (12) | Vector word address for `irq_index` |
| irq_block | output | 1 | Interrupt hold-off request |

## Verification
The bench uses the default parameters: a 12-bit word program counter, a 1024-word largest boot region and a four-cycle window. With these values every program counter value can be swept against every boot size, placement and lock combination, and every interrupt index can be translated under both placements. The short window also lets the bench try a commit at each delay from one to five cycles after arming, so the last accepted slot and the first rejected slot are both exercised.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned IE1_BIT = 7;
   localparam int unsigned IE0_BIT = 6;
   localparam int unsigned SEL_BIT = 1;
   localparam int unsigned CE_BIT  = 0;
   localparam int unsigned NUM_BOOT_SIZES = 4;
endpackage

// File: rtl/ivr_boot_map.sv
module ivr_boot_map #(
   parameter int unsigned PC_W           = 12,
   parameter int unsigned BOOT_MAX_WORDS = 1024
) (
   input  logic [1:0]      boot_size,
   output logic [PC_W-1:0] boot_base
);
   import ivr_pkg::*;
   localparam int unsigned PC_DEPTH = 1 << PC_W;

   if (BOOT_MAX_WORDS >= PC_DEPTH) begin : g_bad_size
      $error("boot region must be smaller than program memory");
   end
   if ((BOOT_MAX_WORDS % 8) != 0) begin : g_bad_align
      $error("largest boot region must be a multiple of 8 words");
   end

   logic [PC_W-1:0] start_tbl [NUM_BOOT_SIZES];

   // each size step halves the region, moving its start upward
   for (genvar k = 0; k < NUM_BOOT_SIZES; k++) begin : g_start
      assign start_tbl[k] = PC_W'(PC_DEPTH - (BOOT_MAX_WORDS >> k));
   end

   assign boot_base = start_tbl[boot_size];
endmodule

// File: rtl/ivr_unlock.sv
module ivr_unlock #(
   parameter int unsigned WIN_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_ce,
   input  logic wr_sel,
   input  logic instr_done,
   output logic sel_q,
   output logic ce_q,
   output logic hold_q,
   output logic arming
);
   localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);

   if (WIN_CYC < 1) begin : g_bad_win
      $error("unlock window must be at least one cycle");
   end

   logic [CNT_W-1:0] win_cnt;
   logic             commit;

   assign arming = wr_en && wr_ce;
   assign commit = wr_en && !wr_ce && ce_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         ce_q    <= 1'b0;
         win_cnt <= '0;
      end else if (arming) begin
         ce_q    <= 1'b1;
         win_cnt <= CNT_W'(WIN_CYC);
      end else if (commit) begin
         sel_q   <= wr_sel;
         ce_q    <= 1'b0;
         win_cnt <= '0;
      end else if (ce_q) begin
         if (win_cnt == CNT_W'(1)) begin
            ce_q    <= 1'b0;
            win_cnt <= '0;
         end else begin
            win_cnt <= win_cnt - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold_q <= 1'b0;
      else if (commit)     hold_q <= 1'b1;
      else if (instr_done) hold_q <= 1'b0;
   end
endmodule

// File: rtl/ivr_lock_gate.sv
module ivr_lock_gate #(
   parameter int unsigned PC_W = 12
) (
   input  logic            sel,
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] boot_base,
   input  logic            lock_app,
   input  logic            lock_boot,
   output logic            lock_blk
);
   logic in_boot;
   assign in_boot  = (pc >= boot_base);
   assign lock_blk = sel ? (lock_app && !in_boot) : (lock_boot && in_boot);
endmodule

// File: rtl/ivr_vec_gen.sv
module ivr_vec_gen #(
   parameter int unsigned PC_W  = 12,
   parameter int unsigned IDX_W = 5
) (
   input  logic             sel,
   input  logic [PC_W-1:0]  boot_base,
   input  logic [IDX_W-1:0] irq_index,
   output logic [PC_W-1:0]  vec_addr
);
   if (IDX_W >= PC_W) begin : g_bad_idx
      $error("interrupt index must be narrower than the address");
   end

   logic [PC_W-1:0] base;
   assign base     = sel ? boot_base : '0;
   assign vec_addr = base + PC_W'(irq_index);
endmodule

// File: rtl/ivec_reloc_ctrl.sv
module ivec_reloc_ctrl #(
   parameter int unsigned PC_W           = 12,
   parameter int unsigned IDX_W          = 5,
   parameter int unsigned BOOT_MAX_WORDS = 1024,
   parameter int unsigned WIN_CYC        = 4,
   parameter bit          LOCK_RULES_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [7:0]       reg_q,
   input  logic [1:0]       boot_size,
   input  logic             lock_app,
   input  logic             lock_boot,
   input  logic [PC_W-1:0]  pc,
   input  logic             instr_done,
   input  logic [IDX_W-1:0] irq_index,
   output logic [PC_W-1:0]  vec_addr,
   output logic             irq_block
);
   import ivr_pkg::*;

   logic            ie1_q, ie0_q;
   logic            sel_q, ce_q, hold_q, arming;
   logic            lock_blk;
   logic [PC_W-1:0] boot_base;
   logic            unused_wr_bits;

   assign unused_wr_bits = ^wr_data[5:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie1_q <= 1'b0;
         ie0_q <= 1'b0;
      end else if (wr_en) begin
         ie1_q <= wr_data[IE1_BIT];
         ie0_q <= wr_data[IE0_BIT];
      end
   end

   ivr_boot_map #(.PC_W(PC_W), .BOOT_MAX_WORDS(BOOT_MAX_WORDS)) u_map (
      .boot_size (boot_size),
      .boot_base (boot_base)
   );

   ivr_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_ce      (wr_data[CE_BIT]),
      .wr_sel     (wr_data[SEL_BIT]),
      .instr_done (instr_done),
      .sel_q      (sel_q),
      .ce_q       (ce_q),
      .hold_q     (hold_q),
      .arming     (arming)
   );

   ivr_vec_gen #(.PC_W(PC_W), .IDX_W(IDX_W)) u_vec (
      .sel       (sel_q),
      .boot_base (boot_base),
      .irq_index (irq_index),
      .vec_addr  (vec_addr)
   );

   if (LOCK_RULES_EN) begin : g_lock
      ivr_lock_gate #(.PC_W(PC_W)) u_gate (
         .sel       (sel_q),
         .pc        (pc),
         .boot_base (boot_base),
         .lock_app  (lock_app),
         .lock_boot (lock_boot),
         .lock_blk  (lock_blk)
      );
   end else begin : g_nolock
      logic unused_lock_in;
      assign unused_lock_in = lock_app ^ lock_boot ^ (^pc);
      assign lock_blk = 1'b0;
   end

   always_comb begin
      reg_q          = '0;
      reg_q[IE1_BIT] = ie1_q;
      reg_q[IE0_BIT] = ie0_q;
      reg_q[SEL_BIT] = sel_q;
      reg_q[CE_BIT]  = ce_q;
   end

   assign irq_block = arming || ce_q || hold_q || lock_blk;
endmodule

// File: rtl/ivr_chk.sv
module ivr_chk #(
   parameter int unsigned PC_W    = 12,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned WIN_CYC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic [7:0]       reg_q,
   input logic [IDX_W-1:0] irq_index,
   input logic [PC_W-1:0]  vec_addr,
   input logic             irq_block
);
   int unsigned open_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  open_run <= 0;
      else if (wr_en && wr_data[0]) open_run <= 1;
      else if (reg_q[0])           open_run <= open_run + 1;
      else                         open_run <= 0;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (reg_q == 8'h00));

   // R5
   window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_q[0] |-> (open_run <= WIN_CYC));

   // R6
   sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_q[1]) |-> $past(wr_en && reg_q[0] && !wr_data[0]));

   // R7
   open_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_q[0] |-> irq_block);

   // R8
   commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_q[0] && !wr_data[0]) |=> (irq_block && !reg_q[0]));

   // R4
   low_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_q[1] |-> (vec_addr == PC_W'(irq_index)));
endmodule

bind ivec_reloc_ctrl ivr_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .WIN_CYC(WIN_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .reg_q     (reg_q),
   .irq_index (irq_index),
   .vec_addr  (vec_addr),
   .irq_block (irq_block)
);

// File: tb/ivec_reloc_ctrl_test.sv
module ivec_reloc_ctrl_test;
   localparam int PC_W = 12;
   localparam int IDX_W = 5;
   localparam int DEPTH = 1 << PC_W;
   localparam int BMAX = 1024;
   localparam int WIN = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [7:0]       wr_data = '0;
   logic [7:0]       reg_q;
   logic [1:0]       boot_size = '0;
   logic             lock_app = 1'b0;
   logic             lock_boot = 1'b0;
   logic [PC_W-1:0]  pc = '0;
   logic             instr_done = 1'b0;
   logic [IDX_W-1:0] irq_index = '0;
   logic [PC_W-1:0]  vec_addr;
   logic             irq_block;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ivec_reloc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .reg_q(reg_q),
      .boot_size(boot_size), .lock_app(lock_app), .lock_boot(lock_boot), .pc(pc),
      .instr_done(instr_done), .irq_index(irq_index), .vec_addr(vec_addr),
      .irq_block(irq_block)
   );

   function automatic int start_of(input int b);
      return DEPTH - (BMAX >> b);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic step();
      @(negedge clk);
      wr_en = 1'b0;
      instr_done = 1'b0;
   endtask

   // set placement bit through a full unlock sequence, then release the hold
   task automatic set_sel(input bit v);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h01;
      step();
      wr_en = 1'b1; wr_data = {6'b0, v, 1'b0};
      step();
      instr_done = 1'b1;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(reg_q == 8'h00, "R1 reg", reg_q, 0);
      chk(irq_block == 1'b0, "R1 block", irq_block, 0);
      irq_index = 5'd7; #1;
      chk(vec_addr == 12'd7, "R1 vec", vec_addr, 7);

      // R2 enables written directly; unused bits read zero; R6 stray sel write ignored
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hFE;
      step(); #1;
      chk(reg_q == 8'hC0, "R2 R6 stray write", reg_q, 8'hC0);
      wr_en = 1'b1; wr_data = 8'h40;
      step(); #1;
      chk(reg_q == 8'h40, "R2 enable", reg_q, 8'h40);
      wr_en = 1'b1; wr_data = 8'h00;
      step(); #1;

      // R4 low base sweep
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 32; i++) begin
            boot_size = b[1:0]; irq_index = i[4:0]; #1;
            chk(vec_addr == i[11:0], "R4 low base", vec_addr, i);
         end

      set_sel(1'b1); #1;
      chk(reg_q == 8'h02, "R6 sel set", reg_q, 2);
      // R3 boot starts and R4 high base sweep
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 32; i++) begin
            boot_size = b[1:0]; irq_index = i[4:0]; #1;
            if (i == 0) chk(vec_addr == start_of(b), "R3 boot start", vec_addr, start_of(b));
            chk(vec_addr == 12'(start_of(b) + i), "R4 high base", vec_addr, start_of(b) + i);
         end
      boot_size = 2'd0; irq_index = 5'h12; #1;
      chk(vec_addr == 12'hC12, "R4 last entry", vec_addr, 12'hC12);

      // R5 R6 R7 R8 commit delay 1..WIN+1
      for (int d = 1; d <= WIN + 1; d++) begin
         bit s;
         s = reg_q[1];
         @(negedge clk); wr_en = 1'b1; wr_data = 8'h01; #1;
         chk(irq_block == 1'b1, "R7 arm cycle", irq_block, 1);
         for (int k = 1; k < d; k++) begin
            step(); #1;
            chk(reg_q[0] == 1'b1, "R5 open", reg_q[0], 1);
            chk(irq_block == 1'b1, "R7 open", irq_block, 1);
         end
         step(); #1;
         if (d <= WIN) chk(reg_q[0] == 1'b1, "R5 last open", reg_q[0], 1);
         else begin
            chk(reg_q[0] == 1'b0, "R5 expired", reg_q[0], 0);
            chk(irq_block == 1'b0, "R7 timeout release", irq_block, 0);
         end
         wr_en = 1'b1; wr_data = {6'b0, ~s, 1'b0};
         step(); #1;
         if (d <= WIN) begin
            chk(reg_q[1] == ~s, "R6 commit", reg_q[1], ~s);
            chk(reg_q[0] == 1'b0, "R6 ce cleared", reg_q[0], 0);
            chk(irq_block == 1'b1, "R8 hold", irq_block, 1);
            step(); #1;
            chk(irq_block == 1'b1, "R8 hold no strobe", irq_block, 1);
            instr_done = 1'b1; #1;
            chk(irq_block == 1'b1, "R8 strobe cycle", irq_block, 1);
            step(); #1;
            chk(irq_block == 1'b0, "R8 release", irq_block, 0);
         end else begin
            chk(reg_q[1] == s, "R6 late write ignored", reg_q[1], s);
            chk(irq_block == 1'b0, "R7 late", irq_block, 0);
         end
      end

      // R11 re-arm restarts window
      begin
         bit s;
         s = reg_q[1];
         @(negedge clk); wr_en = 1'b1; wr_data = 8'h01;
         step(); step(); step();
         wr_en = 1'b1; wr_data = 8'h03;
         for (int k = 1; k <= WIN; k++) begin
            step(); #1;
            chk(reg_q[0] == 1'b1 && reg_q[1] == s, "R11 reopened", reg_q[1:0], {s, 1'b1});
         end
         step(); #1;
         chk(reg_q[0] == 1'b0 && reg_q[1] == s, "R11 expire", reg_q[1:0], {s, 1'b0});
      end

      // R9 R10 lock sweep over all pc values
      for (int sv = 0; sv < 2; sv++) begin
         set_sel(sv[0]);
         for (int b = 0; b < 4; b++)
            for (int l = 0; l < 4; l++)
               for (int p = 0; p < DEPTH; p++) begin
                  bit exp;
                  boot_size = b[1:0]; lock_app = l[0]; lock_boot = l[1]; pc = p[11:0]; #1;
                  exp = sv[0] ? (l[0] && p < start_of(b)) : (l[1] && p >= start_of(b));
                  chk(irq_block == exp, sv[0] ? "R9 lock" : "R10 lock", irq_block, exp);
               end
         lock_app = 1'b0; lock_boot = 1'b0;
      end

      finish_run();
   end
endmodule